// File: doc/BRIEF.md
# Burst Read Output Sequencer

This block is the device-side sequencer for synchronous burst reads from a 16-bit word array. A host starts a burst by giving a start address, a word count and an initial latency. After the latency the block presents consecutive words on its data output, holding each one for one or two clocks. The set of clocks for which one word is held is called a data cycle. A WAIT flag tells the host to hold off while the first word is not yet ready.

Two configuration bits shape the burst. The hold bit chooses how long each word stays on the bus. The wait-timing bit chooses when WAIT drops. It can drop one data cycle before the first word, or in the same cycle that the first word appears. Both bits and the burst parameters are captured when a burst starts.

The block also serves single asynchronous reads, during which WAIT stays low. During host writes it releases the WAIT line, shown by its output-enable flag going low. The array is modelled as a fixed pattern computed from the address.

Top module: `brs_burst_seq`

## Requirements
- R1: With the hold bit at 1, every burst word remains unchanged on `dout` with `dout_oe` high for exactly two clocks.
- R2: With the hold bit at 0, every burst word remains on `dout` for one clock, and a different word follows on each clock of the burst.
- R3: With the wait-timing bit at 1, `wait_o` is high from the first clock after the start edge through clock L-1-H, where t=0 is the first clock after the start edge, L is the latency and H is the hold length (1 or 2). If L-1-H is below 0, `wait_o` never rises.
- R4: With the wait-timing bit at 0, `wait_o` is high for clocks t=0 to L-1 and low from the clock in which the first word appears.
- R5: The first word appears at t=L. A latency input below 2 is used as 2, so the usable range is 2 to 7. `wait_o` rises only on the clock after an accepted start.
- R6: Burst words come from addresses start, start+1, and so on, wrapping modulo 256. The word at address a is {a XOR 8'h3C, a}. A burst carries `burst_len` words, and a count of 0 is used as 1. At t=L+N*H, `dout_oe` is low again and the block is idle.
- R7: An asynchronous read pulse while idle drives the word at `start_addr` for one clock, with `dout_oe` high and `wait_o` low, starting with the clock after the edge.
- R8: `wait_oe` is low while `wr_en` is high and high otherwise.
- R9: Configuration writes and start or read pulses that arrive during a burst do not change that burst. A configuration write takes effect from the next burst.
- R10: A synchronous active-low reset sets both configuration bits to 1 and makes the block idle, with `wait_o` and `dout_oe` low on the clock after reset is sampled.
- R11: `wait_o` is never high while `dout_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Loads the two configuration bits |
| cfg_hold2 | input | 1 | Hold bit: 1 holds each word for two clocks, 0 for one |
| cfg_wait_early | input | 1 | Wait-timing bit: 1 drops WAIT one data cycle early |
| start | input | 1 | Starts a burst when idle |
| start_addr | input | 8 | Burst start address, also the asynchronous read address |
| burst_len | input | 4 | Word count (0 used as 1) |
| latency | input | 3 | Initial latency in clocks (below 2 used as 2) |
| async_rd | input | 1 | Single asynchronous read when idle |
| wr_en | input | 1 | Host write in progress |
| dout | output | 16 | Data output |
| dout_oe | output | 1 | Data output valid / enable |
| wait_o | output | 1 | WAIT, high means data not yet ready |
| wait_oe | output | 1 | WAIT driver enable, low means released |

## Verification
The bench sweeps every pairing of the hold and wait-timing bits across several latencies and lengths. It compares each clock of each burst with a model built from the requirements. An off-by-one in the latency counter, or a hold counter started at the wrong value, would shift a word or a WAIT edge by a clock. Either would show as a mismatch. The sweep includes the case where latency equals the hold length, so WAIT should never rise. A design that underflowed its comparison there would raise WAIT for a whole burst. It also includes an address wrap past 8'hFF and the clamping of a zero length and a short latency. Directed tests write new configuration and pulse start in the middle of a burst, reset in the middle of a burst, and then check that the configuration defaults return. A design that used its configuration without sampling it at the start would change hold or WAIT timing in the middle of a burst.

// File: rtl/brs_pkg.sv
// Shared types for the burst read output sequencer.
// Assumes nothing beyond the parameters of the blocks that import it.
package brs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_DATA  = 2'd2,
        ST_ASYNC = 2'd3
    } brs_state_e;

    typedef struct packed {
        logic hold2;       // 1: two clocks per word
        logic wait_early;  // 1: WAIT drops one data cycle early
    } brs_cfg_t;

endpackage

// File: rtl/brs_cfg_reg.sv
// Configuration register holding the hold and wait-timing bits.
// Assumes a synchronous active-low reset; both bits reset to 1.
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  brs_cfg_t wdata,
    output brs_cfg_t cfg
);

    // Load new configuration on a write, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{hold2: 1'b1, wait_early: 1'b1};
        end else if (we) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/brs_array.sv
// Read-only array model: each word is computed from its address.
// Assumes ADDR_W >= 8 and DATA_W a multiple of 8. Byte lane k is
// the low address byte XOR (8'h3C * k).
module brs_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int LANES = DATA_W / 8;

    logic [7:0] addr_lo;
    assign addr_lo = addr[7:0];

    // One pattern byte per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [7:0] LANE_KEY = 8'((8'h3C * k) & 8'hFF);
        assign data[k*8 +: 8] = addr_lo ^ LANE_KEY;
    end

endmodule

// File: rtl/brs_ctrl.sv
// Burst sequencer state machine: latency count, word hold count,
// address stepping and WAIT generation. Configuration and burst
// parameters are captured at burst start. Assumes rd_data is the
// combinational array word for fetch_addr.
module brs_ctrl
    import brs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 4,
    parameter int LAT_W   = 3,
    parameter int MIN_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  brs_cfg_t          cfg,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [LAT_W-1:0]  latency,
    input  logic              async_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              wait_o,
    output logic              in_data,
    output logic              hold2_q
);

    localparam logic [LAT_W-1:0] LAT_FLOOR = LAT_W'(MIN_LAT);
    localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

    brs_state_e        state_q;
    logic [LAT_W-1:0]  lat_cnt_q;
    logic              hold_cnt_q;
    logic [LEN_W-1:0]  words_left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              early_q;
    logic [DATA_W-1:0] dout_q;

    logic [LAT_W-1:0]  lat_eff;
    logic [LEN_W-1:0]  len_eff;
    logic [LAT_W-1:0]  wait_floor;

    // Clamp burst parameters to their legal range.
    always_comb begin
        lat_eff = (latency < LAT_FLOOR) ? LAT_FLOOR : latency;
        len_eff = (burst_len == '0) ? LEN_ONE : burst_len;
    end

    // Remaining-latency threshold below which WAIT is already low.
    always_comb begin
        if (!early_q)     wait_floor = '0;
        else if (hold2_q) wait_floor = LAT_W'(2);
        else              wait_floor = LAT_W'(1);
    end

    // Array address: live input while idle, stepped pointer otherwise.
    assign fetch_addr = (state_q == ST_IDLE) ? start_addr : addr_q;

    // Main sequencing: idle, latency, data cycles, single async read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            lat_cnt_q    <= '0;
            hold_cnt_q   <= 1'b0;
            words_left_q <= '0;
            addr_q       <= '0;
            hold2_q      <= 1'b1;
            early_q      <= 1'b1;
            dout_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q      <= ST_LAT;
                        lat_cnt_q    <= lat_eff - LAT_W'(1);
                        words_left_q <= len_eff;
                        addr_q       <= start_addr;
                        hold2_q      <= cfg.hold2;
                        early_q      <= cfg.wait_early;
                    end else if (async_rd) begin
                        state_q <= ST_ASYNC;
                        dout_q  <= rd_data;
                    end
                end
                ST_LAT: begin
                    if (lat_cnt_q == '0) begin
                        state_q      <= ST_DATA;
                        dout_q       <= rd_data;
                        addr_q       <= addr_q + ADDR_W'(1);
                        hold_cnt_q   <= hold2_q;
                        words_left_q <= words_left_q - LEN_W'(1);
                    end else begin
                        lat_cnt_q <= lat_cnt_q - LAT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (hold_cnt_q) begin
                        hold_cnt_q <= 1'b0;
                    end else if (words_left_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        dout_q       <= rd_data;
                        addr_q       <= addr_q + ADDR_W'(1);
                        hold_cnt_q   <= hold2_q;
                        words_left_q <= words_left_q - LEN_W'(1);
                    end
                end
                ST_ASYNC: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output flags decoded from registered state.
    always_comb begin
        in_data = (state_q == ST_DATA);
        dout_oe = in_data || (state_q == ST_ASYNC);
        wait_o  = (state_q == ST_LAT) && (lat_cnt_q >= wait_floor);
        dout    = dout_q;
    end

endmodule

// File: rtl/brs_burst_seq.sv
// Top level of the burst read output sequencer: configuration
// register, array model and sequencer. The WAIT driver is released
// whenever the host is writing.
module brs_burst_seq
    import brs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_hold2,
    input  logic              cfg_wait_early,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [LAT_W-1:0]  latency,
    input  logic              async_rd,
    input  logic              wr_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              wait_o,
    output logic              wait_oe
);

    brs_cfg_t          cfg_q;
    brs_cfg_t          cfg_wdata;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] rd_data;
    logic              in_data;
    logic              hold2_q;

    assign cfg_wdata = '{hold2: cfg_hold2, wait_early: cfg_wait_early};

    brs_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    brs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .addr (fetch_addr),
        .data (rd_data)
    );

    brs_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .LAT_W  (LAT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .start      (start),
        .start_addr (start_addr),
        .burst_len  (burst_len),
        .latency    (latency),
        .async_rd   (async_rd),
        .rd_data    (rd_data),
        .fetch_addr (fetch_addr),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .wait_o     (wait_o),
        .in_data    (in_data),
        .hold2_q    (hold2_q)
    );

    // WAIT is released while the host writes.
    assign wait_oe = !wr_en;

endmodule

// File: rtl/brs_burst_seq_chk.sv
// Assertion checker for the burst read output sequencer, bound to
// the top module. Observes ports and the captured hold setting.
module brs_burst_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              wait_o,
    input logic              in_data,
    input logic              hold2_q
);

    // R1: a new burst word under two-clock hold stays a second clock.
    a_r1_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && hold2_q && dout != $past(dout)) |=> (dout_oe && $stable(dout)))
        else $error("a_r1_hold_two");

    // R2: under one-clock hold, consecutive data clocks carry new words.
    a_r2_new_each_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !hold2_q && $past(in_data)) |-> (dout != $past(dout)))
        else $error("a_r2_new_each_clk");

    // R5: WAIT rises only right after an accepted start.
    a_r5_wait_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> $past(start))
        else $error("a_r5_wait_after_start");

    // R11: WAIT never overlaps valid data.
    a_r11_no_wait_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !wait_o)
        else $error("a_r11_no_wait_with_data");

    // R10: reset leaves the block idle.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!wait_o && !dout_oe))
        else $error("a_r10_reset_idle");

endmodule

bind brs_burst_seq brs_burst_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dout    (dout),
    .dout_oe (dout_oe),
    .wait_o  (wait_o),
    .in_data (in_data),
    .hold2_q (hold2_q)
);

// File: tb/brs_burst_seq_bench.sv
module brs_burst_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_hold2 = 1'b0, cfg_wait_early = 1'b0;
    logic        start = 1'b0, async_rd = 1'b0, wr_en = 1'b0;
    logic [7:0]  start_addr = '0;
    logic [3:0]  burst_len = '0;
    logic [2:0]  latency = '0;
    logic [15:0] dout;
    logic        dout_oe, wait_o, wait_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    brs_burst_seq u_brs_burst_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hold2(cfg_hold2),
        .cfg_wait_early(cfg_wait_early), .start(start), .start_addr(start_addr),
        .burst_len(burst_len), .latency(latency), .async_rd(async_rd),
        .wr_en(wr_en), .dout(dout), .dout_oe(dout_oe), .wait_o(wait_o),
        .wait_oe(wait_oe)
    );

    // {hold2, early, latency[2:0], len[3:0], addr[7:0]}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 3'd4, 4'd3,  8'h10},
        {1'b0, 1'b1, 3'd4, 4'd4,  8'h20},
        {1'b1, 1'b0, 3'd3, 4'd2,  8'hFE},
        {1'b0, 1'b0, 3'd2, 4'd5,  8'h40},
        {1'b1, 1'b1, 3'd2, 4'd2,  8'h50},
        {1'b0, 1'b1, 3'd7, 4'd1,  8'h60},
        {1'b1, 1'b0, 3'd0, 4'd0,  8'h70},
        {1'b0, 1'b0, 3'd1, 4'd15, 8'hF8}
    };

    function automatic logic [15:0] word_at(input logic [7:0] a);
        return {a ^ 8'h3C, a};
    endfunction

    task automatic chk(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Runs one burst and compares every clock against the model.
    // exp_* give the expected captured configuration; disturb pulses
    // a config write and start at t=1 (R9).
    task automatic run_burst(input bit wr_cfg, input bit h2, input bit early,
                             input bit exp_h2, input bit exp_early,
                             input logic [2:0] lat, input logic [3:0] len,
                             input logic [7:0] addr, input bit disturb,
                             input string tag);
        int L = (lat < 2) ? 2 : int'(lat);
        int N = (len == 0) ? 1 : int'(len);
        int H = exp_h2 ? 2 : 1;
        if (wr_cfg) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_hold2 = h2; cfg_wait_early = early;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        start = 1'b1; start_addr = addr; burst_len = len; latency = lat;
        for (int t = 0; t <= L + N * H + 1; t++) begin
            @(negedge clk);
            start = 1'b0;
            cfg_we = 1'b0;
            if (disturb && t == 1) begin
                cfg_we = 1'b1; cfg_hold2 = ~exp_h2; cfg_wait_early = ~exp_early;
                start = 1'b1; start_addr = addr ^ 8'h55; latency = 3'd5;
            end
            begin
                bit e_oe = (t >= L) && (t < L + N * H);
                bit e_wait = (t < L) && (t <= L - 1 - H * int'(exp_early));
                logic [15:0] e_d = word_at(addr + 8'((t - L) / H));
                bit ok = (dout_oe == e_oe) && (wait_o == e_wait) && (!e_oe || dout == e_d);
                chk(ok, $sformatf("%s t=%0d oe=%b/%b wait=%b/%b dout=%h/%h",
                                  tag, t, dout_oe, e_oe, wait_o, e_wait, dout, e_d));
            end
        end
        start = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state at the ports.
        chk(!dout_oe && !wait_o && wait_oe,
            $sformatf("R10 reset state oe=%b wait=%b woe=%b exp 0 0 1", dout_oe, wait_o, wait_oe));
        rst_n = 1'b1;

        // Table sweep: R1 R2 R3 R4 R5 R6 R11.
        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] v = VEC[i];
            run_burst(1'b1, v[16], v[15], v[16], v[15], v[14:12], v[11:8], v[7:0], 1'b0,
                      $sformatf("R1/R2/R3/R4/R5/R6 vec%0d", i));
        end

        // R9: mid-burst config write and start pulse ignored.
        run_burst(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd3, 4'd3, 8'h80, 1'b1, "R9 mid-burst");
        // R9: the config written mid-burst (0,0) applies to the next burst.
        run_burst(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3, 8'h90, 1'b0, "R9 next burst");

        // R7: asynchronous read.
        @(negedge clk);
        async_rd = 1'b1; start_addr = 8'h33;
        @(negedge clk);
        async_rd = 1'b0;
        chk(dout_oe && !wait_o && dout == word_at(8'h33),
            $sformatf("R7 async oe=%b wait=%b dout=%h exp 1 0 %h", dout_oe, wait_o, dout, word_at(8'h33)));
        @(negedge clk);
        chk(!dout_oe && !wait_o, $sformatf("R7 async end oe=%b wait=%b exp 0 0", dout_oe, wait_o));

        // R8: WAIT released during writes.
        wr_en = 1'b1;
        #1 chk(!wait_oe, $sformatf("R8 write woe=%b exp 0", wait_oe));
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk(wait_oe, $sformatf("R8 after write woe=%b exp 1", wait_oe));

        // R10: reset mid-burst, then defaults return.
        @(negedge clk);
        cfg_we = 1'b1; cfg_hold2 = 1'b0; cfg_wait_early = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b1; start_addr = 8'hA0; burst_len = 4'd4; latency = 3'd4;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(wait_o, $sformatf("R10 pre-reset wait=%b exp 1", wait_o));
        rst_n = 1'b0;
        @(negedge clk);
        chk(!wait_o && !dout_oe, $sformatf("R10 after reset wait=%b oe=%b exp 0 0", wait_o, dout_oe));
        rst_n = 1'b1;
        run_burst(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 4'd2, 8'hB0, 1'b0, "R10 defaults");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule